// File: doc/BRIEF.md
# Operand Effective Address Unit

This block resolves one instruction operand under a selectable addressing mode. Each request carries a 3-bit mode code, a register index, a signed immediate/displacement field, a memory address field and an operand size code. The unit either returns a value, for the immediate and register modes, or an effective address, for every other mode. A single-cycle `done` strobe marks the result.

The unit reads an external 8 x 32 register file through a combinational read port. For the auto-increment and auto-decrement modes it writes the modified register back through a write port, on the same clock edge that accepts the request. For the memory-indirect mode it issues one read on a request/ready memory port. It then reports the fetched word as the effective address.

Top module: `ea_unit`

## Requirements
- R1: Mode 0 (immediate): `done` is high in the cycle after the accepting edge. `is_value`=1, and `result` is the `imm_disp` field sign-extended to 32 bits.
- R2: Mode 1 (register): `done` follows one cycle after acceptance with `is_value`=1 and `result` equal to the contents of register `reg_idx`.
- R3: Mode 2 (register deferred): `result` is the contents of register `reg_idx` with `is_value`=0. No register is written.
- R4: Mode 3 (post-increment): `result` is the old register contents with `is_value`=0. The register is then increased by the step 1 << `size` (`size` 0/1/2 gives 1/2/4 bytes).
- R5: Mode 4 (pre-decrement): the register is decreased by the step 1 << `size`. `result` is the new, decreased value with `is_value`=0.
- R6: Mode 5 (displacement): `result` is the register contents plus the sign-extended `imm_disp`, modulo 2^32, with `is_value`=0.
- R7: Mode 6 (memory indirect): `mem_req` rises in the cycle after acceptance, with `mem_addr` equal to `addr_fld`. Both hold until an edge with `mem_ready` high. `done` follows in the next cycle with `result` equal to the `mem_rdata` taken at that edge and `is_value`=0.
- R8: Mode 7, and `size`=3 with mode 3 or 4, are illegal. Either gives `done` with `illegal`=1 and `result`=0, and no register is written.
- R9: A `start` that arrives while a memory-indirect read is outstanding is ignored: no register is written and no extra `done` appears.
- R10: After reset, `done`, `illegal`, `mem_req` and `rf_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| reg_idx | input | 3 | Register index |
| imm_disp | input | 16 | Signed immediate or displacement |
| addr_fld | input | 32 | Memory address field for indirect mode |
| size | input | 2 | Operand size code (step = 1 << size) |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register write-back enable |
| rf_waddr | output | 3 | Register write-back index |
| rf_wdata | output | 32 | Register write-back data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ready | input | 1 | Memory read completion |
| mem_rdata | input | 32 | Memory read data |
| done | output | 1 | Result valid strobe |
| result | output | 32 | Value or effective address |
| is_value | output | 1 | 1 when `result` is an operand value |
| illegal | output | 1 | Illegal mode flag, valid with `done` |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, eight registers and a 16-bit displacement field. With a 16-bit field, a negative displacement and an all-ones register value are easy to reach, so wrap-around of the address sum gets exercised. Auto-modified registers are driven across zero so the steps borrow and carry. With a memory port that stalls for several cycles, a second request can be placed inside the outstanding read to test that it is ignored.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    AM_IMM     = 3'd0,
    AM_REG     = 3'd1,
    AM_DEFER   = 3'd2,
    AM_POSTINC = 3'd3,
    AM_PREDEC  = 3'd4,
    AM_DISP    = 3'd5,
    AM_MEMIND  = 3'd6,
    AM_BAD     = 3'd7
  } amode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW = 32,
  parameter int FW = 16
) (
  input  logic [2:0]    mode,
  input  logic [1:0]    size,
  input  logic [AW-1:0] reg_val,
  input  logic [FW-1:0] field,
  output logic [AW-1:0] res,
  output logic          res_is_val,
  output logic          need_mem,
  output logic          wb_en,
  output logic [AW-1:0] wb_data,
  output logic          bad
);
  logic [AW-1:0] sext_field;
  logic [AW-1:0] step;
  logic          size_bad;

  assign sext_field = {{(AW-FW){field[FW-1]}}, field};
  assign step       = AW'(1) << size;
  assign size_bad   = (size == 2'd3);

  always_comb begin
    res        = '0;
    res_is_val = 1'b0;
    need_mem   = 1'b0;
    wb_en      = 1'b0;
    wb_data    = '0;
    bad        = 1'b0;
    unique case (amode_e'(mode))
      AM_IMM: begin
        res        = sext_field;
        res_is_val = 1'b1;
      end
      AM_REG: begin
        res        = reg_val;
        res_is_val = 1'b1;
      end
      AM_DEFER: res = reg_val;
      AM_POSTINC: begin
        if (size_bad) bad = 1'b1;
        else begin
          res     = reg_val;
          wb_en   = 1'b1;
          wb_data = reg_val + step;
        end
      end
      AM_PREDEC: begin
        if (size_bad) bad = 1'b1;
        else begin
          res     = reg_val - step;
          wb_en   = 1'b1;
          wb_data = reg_val - step;
        end
      end
      AM_DISP:   res = reg_val + sext_field;
      AM_MEMIND: need_mem = 1'b1;
      default:   bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] calc_res,
  input  logic          calc_is_val,
  input  logic          calc_need_mem,
  input  logic          calc_bad,
  input  logic [AW-1:0] addr_fld,
  input  logic          mem_ready,
  input  logic [AW-1:0] mem_rdata,
  output logic          accept,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          done,
  output logic [AW-1:0] result,
  output logic          is_value,
  output logic          illegal
);
  ctl_state_e    state_q, state_d;
  logic          req_q, req_d;
  logic [AW-1:0] maddr_q, maddr_d;
  logic          done_q, done_d;
  logic [AW-1:0] res_q, res_d;
  logic          isv_q, isv_d;
  logic          ill_q, ill_d;
  logic          res_en;

  assign accept = start && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    maddr_d = maddr_q;
    done_d  = 1'b0;
    res_d   = res_q;
    isv_d   = isv_q;
    ill_d   = 1'b0;
    res_en  = 1'b0;
    if (state_q == ST_IDLE) begin
      if (accept) begin
        if (calc_need_mem) begin
          state_d = ST_WAIT;
          req_d   = 1'b1;
          maddr_d = addr_fld;
        end else begin
          done_d = 1'b1;
          res_en = 1'b1;
          res_d  = calc_bad ? '0 : calc_res;
          isv_d  = calc_bad ? 1'b0 : calc_is_val;
          ill_d  = calc_bad;
        end
      end
    end else if (mem_ready) begin
      state_d = ST_IDLE;
      req_d   = 1'b0;
      done_d  = 1'b1;
      res_en  = 1'b1;
      res_d   = mem_rdata;
      isv_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      done_q  <= done_d;
      ill_q   <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maddr_q <= '0;
      res_q   <= '0;
      isv_q   <= 1'b0;
    end else begin
      if (accept && calc_need_mem) maddr_q <= maddr_d;
      if (res_en) begin
        res_q <= res_d;
        isv_q <= isv_d;
      end
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = maddr_q;
  assign done     = done_q;
  assign result   = res_q;
  assign is_value = isv_q;
  assign illegal  = ill_q;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
  // R7
  ind_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (done && !is_value && !mem_req));
  // R8
  ill_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && result == '0));
  // R9
  no_done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> !done);
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 8,
  parameter int FW   = 16,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     mode,
  input  logic [RIW-1:0] reg_idx,
  input  logic [FW-1:0]  imm_disp,
  input  logic [AW-1:0]  addr_fld,
  input  logic [1:0]     size,
  output logic [RIW-1:0] rf_raddr,
  input  logic [AW-1:0]  rf_rdata,
  output logic           rf_we,
  output logic [RIW-1:0] rf_waddr,
  output logic [AW-1:0]  rf_wdata,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_ready,
  input  logic [AW-1:0]  mem_rdata,
  output logic           done,
  output logic [AW-1:0]  result,
  output logic           is_value,
  output logic           illegal
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [AW-1:0] c_res, c_wb;
  logic          c_isv, c_mem, c_wb_en, c_bad;
  logic          accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ea_calc #(.AW(AW), .FW(FW)) u_calc (
    .mode(mode), .size(size), .reg_val(rf_rdata), .field(imm_disp),
    .res(c_res), .res_is_val(c_isv), .need_mem(c_mem),
    .wb_en(c_wb_en), .wb_data(c_wb), .bad(c_bad)
  );

  ea_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start),
    .calc_res(c_res), .calc_is_val(c_isv), .calc_need_mem(c_mem),
    .calc_bad(c_bad), .addr_fld(addr_fld),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .accept(accept), .mem_req(mem_req), .mem_addr(mem_addr),
    .done(done), .result(result), .is_value(is_value), .illegal(illegal)
  );

  assign rf_raddr = reg_idx;
  assign rf_waddr = reg_idx;
  assign rf_we    = accept && c_wb_en && rst_int_n;
  assign rf_wdata = c_wb;

  // R8
  wb_mode_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rf_we |-> ((mode == AM_POSTINC || mode == AM_PREDEC) && size != 2'd3));
  // R9
  wb_busy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_req && !mem_ready) |-> !rf_we);
endmodule

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [2:0]  reg_idx = '0;
  logic [15:0] imm_disp = '0;
  logic [31:0] addr_fld = '0;
  logic [1:0]  size = '0;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata;
  logic        done, is_value, illegal;
  logic [31:0] result;
  logic [31:0] regs [8];
  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  ea_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_idx(reg_idx),
    .imm_disp(imm_disp), .addr_fld(addr_fld), .size(size),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .done(done), .result(result),
    .is_value(is_value), .illegal(illegal)
  );

  assign rf_rdata  = regs[rf_raddr];
  assign mem_rdata = mem_addr ^ 32'h5A5A_0000;
  always @(posedge clk) if (rf_we) regs[rf_waddr] <= rf_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic [2:0] r,
                       input logic [15:0] f, input logic [31:0] a, input logic [1:0] s);
    @(negedge clk);
    mode = m; reg_idx = r; imm_disp = f; addr_fld = a; size = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 done", {31'b0, done}, 0);
    chk("R10 illegal", {31'b0, illegal}, 0);
    chk("R10 mem_req", {31'b0, mem_req}, 0);
    chk("R10 rf_we", {31'b0, rf_we}, 0);
  endtask

  task automatic t_imm;
    issue(3'd0, 3'd0, 16'h8003, 32'h0, 2'd0);
    chk("R1 done", {31'b0, done}, 1);
    chk("R1 value", result, 32'hFFFF_8003);
    chk("R1 is_value", {31'b0, is_value}, 1);
  endtask

  task automatic t_reg;
    issue(3'd1, 3'd2, 16'h0, 32'h0, 2'd0);
    chk("R2 value", result, 32'h2222_0002);
    chk("R2 is_value", {31'b0, is_value}, 1);
  endtask

  task automatic t_defer;
    issue(3'd2, 3'd5, 16'h0, 32'h0, 2'd2);
    chk("R3 ea", result, 32'h5555_0005);
    chk("R3 is_value", {31'b0, is_value}, 0);
    chk("R3 no write", regs[5], 32'h5555_0005);
  endtask

  task automatic t_postinc;
    regs[1] = 32'hFFFF_FFFE;
    issue(3'd3, 3'd1, 16'h0, 32'h0, 2'd2);
    chk("R4 ea old", result, 32'hFFFF_FFFE);
    chk("R4 reg +4", regs[1], 32'h0000_0002);
    issue(3'd3, 3'd1, 16'h0, 32'h0, 2'd0);
    chk("R4 ea", result, 32'h0000_0002);
    chk("R4 reg +1", regs[1], 32'h0000_0003);
  endtask

  task automatic t_predec;
    regs[4] = 32'h0000_0001;
    issue(3'd4, 3'd4, 16'h0, 32'h0, 2'd1);
    chk("R5 ea new", result, 32'hFFFF_FFFF);
    chk("R5 reg -2", regs[4], 32'hFFFF_FFFF);
    chk("R5 is_value", {31'b0, is_value}, 0);
  endtask

  task automatic t_disp;
    issue(3'd5, 3'd6, 16'hFFF0, 32'h0, 2'd0);
    chk("R6 neg disp", result, 32'h6666_0006 - 32'h10);
    regs[7] = 32'hFFFF_FFFF;
    issue(3'd5, 3'd7, 16'h0002, 32'h0, 2'd0);
    chk("R6 wrap", result, 32'h0000_0001);
  endtask

  task automatic t_illegal;
    regs[3] = 32'h0000_0100;
    issue(3'd7, 3'd3, 16'h1234, 32'h0, 2'd0);
    chk("R8 mode7 illegal", {31'b0, illegal}, 1);
    chk("R8 mode7 done", {31'b0, done}, 1);
    chk("R8 result zero", result, 0);
    issue(3'd3, 3'd3, 16'h0, 32'h0, 2'd3);
    chk("R8 size3 illegal", {31'b0, illegal}, 1);
    chk("R8 no write", regs[3], 32'h0000_0100);
  endtask

  task automatic t_memind;
    regs[3] = 32'h0000_0100;
    issue(3'd6, 3'd0, 16'h0, 32'h0000_4000, 2'd0);
    chk("R7 req", {31'b0, mem_req}, 1);
    chk("R7 addr", mem_addr, 32'h0000_4000);
    chk("R7 no done", {31'b0, done}, 0);
    mode = 3'd3; reg_idx = 3'd3; size = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 no done", {31'b0, done}, 0);
    chk("R7 req held", {31'b0, mem_req}, 1);
    @(negedge clk);
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk("R7 done", {31'b0, done}, 1);
    chk("R7 ea", result, 32'h5A5A_4000);
    chk("R7 is_value", {31'b0, is_value}, 0);
    chk("R7 req drop", {31'b0, mem_req}, 0);
    chk("R9 reg untouched", regs[3], 32'h0000_0100);
    @(negedge clk);
    chk("R9 single done", {31'b0, done}, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = {16'h1111 * i[15:0], 16'(i)};
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_imm;
    t_reg;
    t_defer;
    t_postinc;
    t_predec;
    t_disp;
    t_illegal;
    t_memind;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule